// File: doc/BRIEF.md
# Latched Shared-Memory Address Decoder

This block decodes bus memory addresses for an adapter card that exposes two regions to the host: a shared packet-memory window and a boot ROM window. The top seven latchable address lines are compared against a configured base for each region. This compare is available early in the cycle, before the address strobe drops. Its shared-memory result directly drives the active-low 16-bit memory chip-select. The boot ROM is treated as an 8-bit device, so a ROM hit never drives that chip-select.

The same compare result is held while the strobe is low. The held value is combined with three lower system address lines, which pick a 16 KB window inside the 128 KB upper region. This produces the final shared-memory and boot-ROM match outputs. When the strobe is high, the hold stage passes the live compare straight through. The block samples the strobe on its clock, so the value it keeps is the compare seen at the last clock edge with the strobe high. In an 8-bit host slot the upper lines are not driven and must read as zero; a mode input forces them to zero.

Top module: `sma_addr_decoder`

## Requirements
- R1: `memcs16_n_o` is 0 exactly when the effective upper address equals `shm_base_i`, and 1 otherwise. It reacts in the same cycle and does not depend on `bale_i`, `sa_i` or any held state.
- R2: An upper address that equals `rom_base_i` but not `shm_base_i` leaves `memcs16_n_o` at 1.
- R3: While `bale_i` is 1, the two match outputs follow the live upper-address compare in the same cycle.
- R4: While `bale_i` is 0, the match outputs use the compare that was captured at the last rising clock edge with `bale_i` at 1. Changes on `la_i` have no effect on them until `bale_i` returns to 1.
- R5: `shm_hit_o` needs `sa_i` to equal `shm_win_i`, and `rom_hit_o` needs `sa_i` to equal `rom_win_i`. `sa_i` is always used live, including while the compare is held.
- R6: When both regions qualify, `shm_hit_o` is 1 and `rom_hit_o` is 0.
- R7: When `bus16_i` is 0, the upper address is taken as all zeros, whatever value is on `la_i`.
- R8: After reset the held compare is cleared. With `bale_i` at 0, both match outputs are 0 until a clock edge with `bale_i` at 1 has captured a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the address strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| bale_i | input | 1 | Address-latch strobe: 1 = pass the compare through, 0 = hold it |
| bus16_i | input | 1 | 1 = upper lines are driven; 0 = 8-bit slot, upper lines read as zero |
| la_i | input | 7 | Upper address lines, bits 23..17 |
| sa_i | input | 3 | System address bits 16..14, which select the 16 KB window |
| shm_base_i | input | 7 | Configured upper address of the shared-memory region |
| shm_win_i | input | 3 | Configured 16 KB window of the shared memory |
| rom_base_i | input | 7 | Configured upper address of the boot-ROM region |
| rom_win_i | input | 3 | Configured 16 KB window of the boot ROM |
| memcs16_n_o | output | 1 | Active-low 16-bit memory chip-select, from the live compare |
| shm_hit_o | output | 1 | Shared-memory match |
| rom_hit_o | output | 1 | Boot-ROM match |

## Verification
All three outputs are combinational from the inputs and the held compare. Every result is due in the same cycle its stimulus is applied. The held compare changes only at a rising clock edge taken while `bale_i` is 1, and it affects the outputs from the following cycle on. The bench applies stimulus just after a falling edge and samples 8 ns later, before the next rising edge. Its reference model updates its own copy of the held compare once per step, and only when the previous step had the strobe high.

// File: rtl/sma_pkg.sv
package sma_pkg;

  typedef struct packed {
    logic shm;
    logic rom;
  } sma_pair_t;

  // Gate each region by its window qualifier; shared memory wins when both hit.
  function automatic sma_pair_t sma_resolve(sma_pair_t upper, logic shm_win_ok,
                                            logic rom_win_ok);
    sma_pair_t r;
    r.shm = upper.shm & shm_win_ok;
    r.rom = upper.rom & rom_win_ok & ~r.shm;
    return r;
  endfunction

endpackage

// File: rtl/sma_la_compare.sv
module sma_la_compare
  import sma_pkg::*;
#(
  parameter int LA_W = 7
) (
  input  logic            bus16_i,
  input  logic [LA_W-1:0] la_i,
  input  logic [LA_W-1:0] shm_base_i,
  input  logic [LA_W-1:0] rom_base_i,
  output sma_pair_t       upper_o
);

  function automatic logic [LA_W-1:0] eff_upper(logic drv, logic [LA_W-1:0] la);
    return drv ? la : '0;
  endfunction

  logic [LA_W-1:0] la_eff;

  always_comb begin
    la_eff      = eff_upper(bus16_i, la_i);
    upper_o.shm = (la_eff == shm_base_i);
    upper_o.rom = (la_eff == rom_base_i);
  end

endmodule

// File: rtl/sma_hold_stage.sv
module sma_hold_stage
  import sma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bale_i,
  input  sma_pair_t live_i,
  output sma_pair_t held_o,
  output sma_pair_t eff_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= '0;
    end else if (bale_i) begin
      held_o <= live_i;
    end
  end

  // Transparent while the strobe is high, frozen once it falls.
  assign eff_o = bale_i ? live_i : held_o;

endmodule

// File: rtl/sma_select.sv
module sma_select
  import sma_pkg::*;
#(
  parameter int SA_W = 3
) (
  input  sma_pair_t       eff_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic [SA_W-1:0] shm_win_i,
  input  logic [SA_W-1:0] rom_win_i,
  output sma_pair_t       hit_o
);

  logic shm_win_ok, rom_win_ok;

  assign shm_win_ok = (sa_i == shm_win_i);
  assign rom_win_ok = (sa_i == rom_win_i);
  assign hit_o      = sma_resolve(eff_i, shm_win_ok, rom_win_ok);

endmodule

// File: rtl/sma_addr_decoder.sv
module sma_addr_decoder
  import sma_pkg::*;
#(
  parameter int LA_W = 7,
  parameter int SA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bale_i,
  input  logic            bus16_i,
  input  logic [LA_W-1:0] la_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic [LA_W-1:0] shm_base_i,
  input  logic [SA_W-1:0] shm_win_i,
  input  logic [LA_W-1:0] rom_base_i,
  input  logic [SA_W-1:0] rom_win_i,
  output logic            memcs16_n_o,
  output logic            shm_hit_o,
  output logic            rom_hit_o
);

  // Named internal events, visible to the bound checker.
  sma_pair_t upper_hit;
  sma_pair_t held_hit;
  sma_pair_t eff_hit;
  sma_pair_t sel_hit;

  sma_la_compare #(.LA_W(LA_W)) u_cmp (
    .bus16_i    (bus16_i),
    .la_i       (la_i),
    .shm_base_i (shm_base_i),
    .rom_base_i (rom_base_i),
    .upper_o    (upper_hit)
  );

  sma_hold_stage u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .bale_i (bale_i),
    .live_i (upper_hit),
    .held_o (held_hit),
    .eff_o  (eff_hit)
  );

  sma_select #(.SA_W(SA_W)) u_sel (
    .eff_i     (eff_hit),
    .sa_i      (sa_i),
    .shm_win_i (shm_win_i),
    .rom_win_i (rom_win_i),
    .hit_o     (sel_hit)
  );

  // Only shared memory is 16 bits wide; the ROM is left 8-bit.
  assign memcs16_n_o = ~upper_hit.shm;
  assign shm_hit_o   = sel_hit.shm;
  assign rom_hit_o   = sel_hit.rom;

endmodule

// File: rtl/sma_addr_decoder_chk.sv
module sma_addr_decoder_chk
  import sma_pkg::*;
#(
  parameter int LA_W = 7,
  parameter int SA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bale_i,
  input logic            bus16_i,
  input logic [LA_W-1:0] la_i,
  input logic [SA_W-1:0] sa_i,
  input logic [LA_W-1:0] shm_base_i,
  input logic [SA_W-1:0] shm_win_i,
  input logic [LA_W-1:0] rom_base_i,
  input logic [SA_W-1:0] rom_win_i,
  input logic            memcs16_n_o,
  input logic            shm_hit_o,
  input logic            rom_hit_o,
  input sma_pair_t       upper_hit,
  input sma_pair_t       held_hit
);

  AST_CS_FROM_LA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus16_i && la_i == shm_base_i) |-> !memcs16_n_o); // R1

  AST_ROM_NOT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus16_i && la_i == rom_base_i && la_i != shm_base_i) |-> memcs16_n_o); // R2

  AST_CAPTURE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bale_i)) |-> (held_hit == $past(upper_hit))); // R3

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!bale_i && $past(!bale_i)) |-> $stable(held_hit)); // R4

  AST_SHM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    shm_hit_o |-> (sa_i == shm_win_i)); // R5

  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit_o |-> (sa_i == rom_win_i)); // R5

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(shm_hit_o && rom_hit_o)); // R6

  AST_NARROW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus16_i |-> (memcs16_n_o == (shm_base_i != '0))); // R7

endmodule

bind sma_addr_decoder sma_addr_decoder_chk #(.LA_W(LA_W), .SA_W(SA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bale_i      (bale_i),
  .bus16_i     (bus16_i),
  .la_i        (la_i),
  .sa_i        (sa_i),
  .shm_base_i  (shm_base_i),
  .shm_win_i   (shm_win_i),
  .rom_base_i  (rom_base_i),
  .rom_win_i   (rom_win_i),
  .memcs16_n_o (memcs16_n_o),
  .shm_hit_o   (shm_hit_o),
  .rom_hit_o   (rom_hit_o),
  .upper_hit   (upper_hit),
  .held_hit    (held_hit)
);

// File: tb/sma_addr_decoder_tb.sv
module sma_addr_decoder_tb;

  localparam int LA_W = 7;
  localparam int SA_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bale_i = 1'b0, bus16_i = 1'b1;
  logic [LA_W-1:0] la_i = '0, shm_base_i = 7'h06, rom_base_i = 7'h66;
  logic [SA_W-1:0] sa_i = '0, shm_win_i = 3'd2, rom_win_i = 3'd5;
  logic memcs16_n_o, shm_hit_o, rom_hit_o;

  always #10 clk = ~clk;

  sma_addr_decoder #(.LA_W(LA_W), .SA_W(SA_W)) u_dut (.*);

  typedef struct {
    logic  cs_n;
    logic  shm;
    logic  rom;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0, mismatched = 0;
  logic m_held_shm = 1'b0, m_held_rom = 1'b0;
  logic p_bale = 1'b0, p_live_shm = 1'b0, p_live_rom = 1'b0;
  bit   done = 1'b0;

  // Driver: apply inputs after a falling edge and push the expected result.
  task automatic step(input logic bale, input logic b16, input logic [LA_W-1:0] la,
                      input logic [SA_W-1:0] sa, input bit chk, input string tag);
    logic [LA_W-1:0] up;
    logic live_s, live_r, e_s, e_r, win_s;
    exp_t it;
    @(negedge clk);
    if (p_bale) begin
      m_held_shm = p_live_shm;
      m_held_rom = p_live_rom;
    end
    bale_i = bale; bus16_i = b16; la_i = la; sa_i = sa;
    up     = b16 ? la : 7'h00;
    live_s = (up == shm_base_i);
    live_r = (up == rom_base_i);
    e_s    = bale ? live_s : m_held_shm;
    e_r    = bale ? live_r : m_held_rom;
    win_s  = e_s && (sa == shm_win_i);
    it.cs_n = !live_s;
    it.shm  = win_s;
    it.rom  = e_r && (sa == rom_win_i) && !win_s;
    it.tag  = tag;
    if (chk) exp_q.push_back(it);
    p_bale = bale; p_live_shm = live_s; p_live_rom = live_r;
  endtask

  // Monitor: compare 8 ns after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #8;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (memcs16_n_o !== e.cs_n || shm_hit_o !== e.shm || rom_hit_o !== e.rom) begin
          mismatched++;
          $display("FAIL %s: got cs_n=%b shm=%b rom=%b expected cs_n=%b shm=%b rom=%b",
                   e.tag, memcs16_n_o, shm_hit_o, rom_hit_o, e.cs_n, e.shm, e.rom);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: nothing captured yet, strobe low -> no select despite matching lines.
    step(0, 1, 7'h06, 3'd2, 1, "R8 cleared hold after reset");
    step(0, 1, 7'h66, 3'd5, 1, "R8 rom lines, nothing captured");
    // R3: transparent while strobe is high.
    step(1, 1, 7'h06, 3'd2, 1, "R3 shm live");
    step(1, 1, 7'h66, 3'd5, 1, "R3 rom live follows la change");
    step(1, 1, 7'h06, 3'd2, 1, "R3 shm live again");
    // R4 / R1: held after the strobe falls; chip-select follows la.
    step(0, 1, 7'h11, 3'd2, 1, "R4 held shm, R1 cs released");
    step(0, 1, 7'h66, 3'd2, 1, "R4 la change ignored, R2 rom la no cs");
    step(0, 1, 7'h06, 3'd3, 1, "R5 sa off window while held, R1 cs");
    // R2: ROM capture, chip-select stays high.
    step(1, 1, 7'h66, 3'd5, 1, "R2 rom hit without cs");
    step(0, 1, 7'h06, 3'd5, 1, "R4 rom held, R1 cs from live la");
    step(0, 1, 7'h06, 3'd2, 1, "R5 live sa leaves rom window");
    // R5: sweep the window field.
    for (int k = 0; k < 8; k++) step(1, 1, 7'h06, k[SA_W-1:0], 1, "R5 shm window sweep");
    for (int k = 0; k < 8; k++) step(1, 1, 7'h66, k[SA_W-1:0], 1, "R5 rom window sweep");
    // R6: overlapping regions.
    @(negedge clk); rom_base_i = 7'h06; rom_win_i = 3'd2;
    step(1, 1, 7'h06, 3'd2, 1, "R6 both match, shm priority");
    step(0, 1, 7'h40, 3'd2, 1, "R6 priority while held");
    @(negedge clk); rom_win_i = 3'd4;
    step(1, 1, 7'h06, 3'd4, 1, "R6 same base other window rom");
    // R7: narrow slot forces zero upper address.
    @(negedge clk); shm_base_i = 7'h00; rom_base_i = 7'h33;
    step(1, 0, 7'h7F, 3'd2, 1, "R7 narrow slot reads zero");
    step(1, 0, 7'h33, 3'd4, 1, "R7 narrow slot masks rom la");
    step(1, 1, 7'h33, 3'd4, 1, "R7 wide slot sees rom la");
    @(negedge clk); shm_base_i = 7'h21;
    step(1, 0, 7'h21, 3'd2, 1, "R7 nonzero base misses in narrow slot");
    step(0, 0, 7'h21, 3'd2, 1, "R1 cs high held nothing");
    step(0, 0, 7'h21, 3'd2, 0, "idle");
    @(negedge clk); #12;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule